// File: doc/BRIEF.md
# IRIG-B Frame Symbol Encoder

This block turns a time of day and a day number into the ordered sequence of one hundred symbols that makes up one IRIG-B frame. Software or a clock core presents seconds, minutes, hours and day-of-year as plain binary numbers and pulses a start input. The encoder captures those values, splits each into decimal digits, and then emits one symbol per valid/ready handshake. Each symbol is a reference or position marker, a zero or a one. A waveform stage further down the chain turns each symbol into modulated carrier periods.

Digits go out least significant bit first. They are interleaved with index bits, empty filler bits and a marker in every tenth slot. Fields that carry no time information are sent as zero symbols. A busy flag covers the whole frame. A last flag marks the final symbol, so the consumer can line up the next frame.

Top module: `irig_frame_enc`

## Requirements
- R1: After reset `busy_o`, `valid_o` and `last_o` are all 0.
- R2: A `start_i` pulse seen while idle captures the four time inputs. In the next cycle `busy_o` and `valid_o` are 1 and the symbol for slot 0 is presented.
- R3: Symbol codes are 2'b00 for zero, 2'b01 for one and 2'b10 for marker; 2'b11 is never presented. Slot 0 and every slot whose index ends in 9 (9, 19 ... 99) carry the marker.
- R4: Seconds units occupy slots 1 to 4, LSB in slot 1. Slot 5 is a zero index bit. Seconds tens occupy slots 6 to 8, LSB in slot 6.
- R5: Minutes units occupy slots 10 to 13 and minutes tens occupy slots 15 to 17, each LSB first. Slots 14 and 18 are zero.
- R6: Hours units occupy slots 20 to 23 and hours tens occupy slots 25 and 26, each LSB first, with the tens digit taken from the hours value. Slots 24, 27 and 28 are zero.
- R7: Day-of-year units occupy slots 30 to 33 and tens occupy slots 35 to 38. Hundreds occupy slots 40 and 41. All three are sent LSB first, and slot 34 is zero.
- R8: Slots 42 to 48 and every non-marker slot from 50 to 98 carry the zero symbol.
- R9: The presented symbol stays unchanged while `ready_i` is low. Each cycle with `valid_o` and `ready_i` both high advances exactly one slot.
- R10: `last_o` is 1 only while slot 99 is presented. After the handshake of slot 99, `busy_o` and `valid_o` are 0 in the next cycle.
- R11: Changes on the time inputs after the start pulse do not alter the frame in progress.
- R12: A start pulse that arrives while busy, including in the cycle of the final handshake, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a frame with the present time inputs |
| sec_i | input | 6 | Seconds, binary 0..59 |
| min_i | input | 6 | Minutes, binary 0..59 |
| hour_i | input | 5 | Hours, binary 0..23 |
| doy_i | input | 9 | Day of year, binary 1..366 |
| ready_i | input | 1 | Consumer accepts the presented symbol |
| valid_o | output | 1 | A symbol is presented |
| code_o | output | 2 | Symbol code: 00 zero, 01 one, 10 marker |
| last_o | output | 1 | Presented symbol is slot 99 |
| busy_o | output | 1 | A frame is in progress |

## Verification
The hardest situation to reach is a frame whose content must stay frozen while its surroundings keep moving. The consumer stalls at random, the time inputs are re-randomised in the middle of the frame, and stray start pulses arrive, some of them in the very cycle of the final handshake. The bench meets this by throttling `ready_i` at random on every cycle. It also scrambles the inputs and pulses `start_i` at random during each frame, then compares all hundred symbols with the values captured at the start. A directed frame for 14:10:07 on day 295 is checked against the known symbol string. Extreme times such as 23:59:59 on day 366 and all-zero inputs exercise every digit bit.

// File: rtl/irig_pkg.sv
package irig_pkg;
    localparam int FRAME_SLOTS = 100;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS);
    localparam int GROUP_LEN   = 10;
    localparam int SEC_W       = 6;
    localparam int MIN_W       = 6;
    localparam int HOUR_W      = 5;
    localparam int DOY_W       = 9;
    localparam int DIGIT_W     = 4;
    localparam int NUM_DIGITS  = 9;   // 2 sec, 2 min, 2 hour, 3 day
    localparam int DSEL_W      = $clog2(NUM_DIGITS);

    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_ONE  = 2'b01,
        SYM_MARK = 2'b10
    } sym_t;

    typedef struct packed {
        logic              busy;
        logic [SLOT_W-1:0] slot;
        logic [SEC_W-1:0]  sec;
        logic [MIN_W-1:0]  min;
        logic [HOUR_W-1:0] hour;
        logic [DOY_W-1:0]  doy;
    } enc_state_t;
endpackage

// File: rtl/irig_bcd_split.sv
module irig_bcd_split #(
    parameter int IN_W   = 9,
    parameter int DIGITS = 3
) (
    input  logic [IN_W-1:0]              bin_i,
    output logic [DIGITS-1:0][3:0]       dig_o
);
    function automatic int unsigned pow10(input int n);
        int unsigned r = 1;
        for (int i = 0; i < n; i++) r = r * 10;
        return r;
    endfunction

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        localparam int unsigned SCALE = pow10(g);
        assign dig_o[g] = 4'((32'(bin_i) / SCALE) % 10);
    end
endmodule

// File: rtl/irig_slot_map.sv
module irig_slot_map
    import irig_pkg::*;
(
    input  logic [SLOT_W-1:0]                   slot_i,
    input  logic [NUM_DIGITS-1:0][DIGIT_W-1:0]  dig_i,
    output sym_t                                code_o
);
    // digit order: 0 sec units, 1 sec tens, 2 min units, 3 min tens,
    // 4 hour units, 5 hour tens, 6 day units, 7 day tens, 8 day hundreds
    logic               is_mark;
    logic               is_data;
    logic [DSEL_W-1:0]  dsel;
    logic [SLOT_W-1:0]  base;
    logic [SLOT_W-1:0]  offs;

    always_comb begin
        is_mark = (slot_i == '0) || ((32'(slot_i) % GROUP_LEN) == GROUP_LEN - 1);
        is_data = 1'b1;
        dsel    = '0;
        base    = '0;
        case (slot_i) inside
            [7'd1:7'd4]:   begin dsel = DSEL_W'(0); base = 7'd1;  end
            [7'd6:7'd8]:   begin dsel = DSEL_W'(1); base = 7'd6;  end
            [7'd10:7'd13]: begin dsel = DSEL_W'(2); base = 7'd10; end
            [7'd15:7'd17]: begin dsel = DSEL_W'(3); base = 7'd15; end
            [7'd20:7'd23]: begin dsel = DSEL_W'(4); base = 7'd20; end
            [7'd25:7'd26]: begin dsel = DSEL_W'(5); base = 7'd25; end
            [7'd30:7'd33]: begin dsel = DSEL_W'(6); base = 7'd30; end
            [7'd35:7'd38]: begin dsel = DSEL_W'(7); base = 7'd35; end
            [7'd40:7'd41]: begin dsel = DSEL_W'(8); base = 7'd40; end
            default:       is_data = 1'b0;
        endcase
        offs = slot_i - base;
        if (is_mark)
            code_o = SYM_MARK;
        else if (is_data && dig_i[dsel][offs[1:0]])
            code_o = SYM_ONE;
        else
            code_o = SYM_ZERO;
    end
endmodule

// File: rtl/irig_frame_enc.sv
module irig_frame_enc
    import irig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [MIN_W-1:0]  min_i,
    input  logic [HOUR_W-1:0] hour_i,
    input  logic [DOY_W-1:0]  doy_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [1:0]        code_o,
    output logic              last_o,
    output logic              busy_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);

    enc_state_t st_d, st_q;
    logic       take;
    sym_t       sym;
    logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digits;

    irig_bcd_split #(.IN_W(SEC_W),  .DIGITS(2)) u_sec  (.bin_i(st_q.sec),  .dig_o(digits[1:0]));
    irig_bcd_split #(.IN_W(MIN_W),  .DIGITS(2)) u_min  (.bin_i(st_q.min),  .dig_o(digits[3:2]));
    irig_bcd_split #(.IN_W(HOUR_W), .DIGITS(2)) u_hour (.bin_i(st_q.hour), .dig_o(digits[5:4]));
    irig_bcd_split #(.IN_W(DOY_W),  .DIGITS(3)) u_doy  (.bin_i(st_q.doy),  .dig_o(digits[8:6]));

    irig_slot_map u_map (.slot_i(st_q.slot), .dig_i(digits), .code_o(sym));

    always_comb begin
        st_d = st_q;
        take = st_q.busy && ready_i;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.slot = '0;
                st_d.sec  = sec_i;
                st_d.min  = min_i;
                st_d.hour = hour_i;
                st_d.doy  = doy_i;
            end
        end else if (take) begin
            if (st_q.slot == LAST_SLOT)
                st_d.busy = 1'b0;
            else
                st_d.slot = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o  = st_q.busy;
    assign valid_o = st_q.busy;
    assign code_o  = sym;
    assign last_o  = st_q.busy && (st_q.slot == LAST_SLOT);

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (valid_o && st_q.slot == '0)); // R2
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (code_o != 2'b11)); // R3
    AST_MARKER_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (st_q.slot == '0 || (32'(st_q.slot) % GROUP_LEN) == GROUP_LEN - 1))
        |-> (code_o == 2'b10)); // R3
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(code_o) && $stable(st_q.slot))); // R9
    AST_STEP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && !last_o) |=> (valid_o && st_q.slot == $past(st_q.slot) + 1'b1)); // R9
    AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && last_o) |=> (!busy_o && !valid_o)); // R10
    AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(st_q.sec) && $stable(st_q.min)
                                       && $stable(st_q.hour) && $stable(st_q.doy))); // R11
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !(ready_i && last_o)) |=> busy_o); // R12
endmodule

// File: tb/tb_irig_frame_enc.sv
module tb_irig_frame_enc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [5:0] sec_i = '0;
    logic [5:0] min_i = '0;
    logic [4:0] hour_i = '0;
    logic [8:0] doy_i = '0;
    logic       ready_i = 1'b0;
    logic       valid_o, last_o, busy_o;
    logic [1:0] code_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [1:0] exp_f [100];

    irig_frame_enc dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic void put_bits(input int first, input int nb, input int val);
        for (int i = 0; i < nb; i++)
            exp_f[first + i] = ((val >> i) & 1) ? 2'b01 : 2'b00;
    endfunction

    function automatic void build_frame(input int s, input int m, input int h, input int d);
        for (int k = 0; k < 100; k++) exp_f[k] = (k == 0 || k % 10 == 9) ? 2'b10 : 2'b00;
        put_bits(1, 4, s % 10);   put_bits(6, 3, s / 10);
        put_bits(10, 4, m % 10);  put_bits(15, 3, m / 10);
        put_bits(20, 4, h % 10);  put_bits(25, 2, h / 10);
        put_bits(30, 4, d % 10);  put_bits(35, 4, (d / 10) % 10);
        put_bits(40, 2, d / 100);
    endfunction

    function automatic void build_from_text(input string t);
        for (int k = 0; k < 100; k++)
            exp_f[k] = (t[k] == "R" || t[k] == "P") ? 2'b10 : (t[k] == "1") ? 2'b01 : 2'b00;
    endfunction

    function automatic string req_for(input int k);
        if (k == 0 || k % 10 == 9) return "R3";
        if (k < 10) return "R4";
        if (k < 20) return "R5";
        if (k < 30) return "R6";
        if (k < 42) return "R7";
        return "R8";
    endfunction

    task automatic run_frame(input int s, input int m, input int h, input int d, input bit scramble);
        int k = 0;
        int miss = 0;
        bit hold = 0;
        logic [1:0] held = '0;
        @(negedge clk);
        sec_i = 6'(s); min_i = 6'(m); hour_i = 5'(h); doy_i = 9'(d);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(valid_o && busy_o, "R2", int'(valid_o), 1, "valid after start");
        while (k < 100) begin
            if (hold) chk(valid_o && code_o == held, "R9", int'(code_o), int'(held), "stalled symbol");
            ready_i = ($urandom % 4) != 0;
            if (valid_o && ready_i) begin
                if (code_o != exp_f[k]) miss++;
                chk(code_o == exp_f[k], req_for(k), int'(code_o), int'(exp_f[k]), $sformatf("slot %0d", k));
                chk(last_o == (k == 99), "R10", int'(last_o), int'(k == 99), $sformatf("last at slot %0d", k));
                k++;
                hold = 0;
            end else begin
                hold = valid_o;
                held = code_o;
            end
            if (scramble) begin
                sec_i = 6'($urandom % 60); min_i = 6'($urandom % 60);
                hour_i = 5'($urandom % 24); doy_i = 9'($urandom % 366 + 1);
                start_i = ($urandom % 6) == 0 || k == 99;
            end
            @(negedge clk);
        end
        chk(!busy_o && !valid_o, "R10", int'(busy_o), 0, "busy after final handshake");
        chk(!busy_o, "R12", int'(busy_o), 0, "start during frame ignored");
        chk(miss == 0, "R11", miss, 0, "symbols disturbed by input changes");
        start_i = 1'b0;
        ready_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240521));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !valid_o && !last_o, "R1", int'(busy_o), 0, "reset state");

        build_from_text({"R1110I000P0000I100EP0010I10EEP1010I1001P01EEEEEEEP",
                         "EEEEEEEEEPEEEEEEEEEPEEEEEEEEEPEEEEEEEEEPEEEEEEEEEP"});
        run_frame(7, 10, 14, 295, 1'b0);

        build_frame(59, 59, 23, 366);
        run_frame(59, 59, 23, 366, 1'b1);
        build_frame(0, 0, 0, 0);
        run_frame(0, 0, 0, 0, 1'b1);
        build_frame(38, 45, 19, 100);
        run_frame(38, 45, 19, 100, 1'b1);

        for (int f = 0; f < 16; f++) begin
            int s = $urandom % 60;
            int m = $urandom % 60;
            int h = $urandom % 24;
            int d = $urandom % 366 + 1;
            build_frame(s, m, h, d);
            run_frame(s, m, h, d, 1'b1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule